// File: doc/BRIEF.md
# Decimal Shift, Round and Normalise Unit

This unit works on a signed 20-digit decimal accumulator held as two 10-digit halves, an upper and a lower, with one common sign. The halves are binary-coded decimal, four bits per digit, with the most significant digit in the top nibble. The unit runs four commands. It can move the whole pair left by a digit count. It can move the pair right by a digit count. It can move right and then round on the last digit lost. It can also move left until the top digit of the upper half is nonzero, keeping a count of the moves. The digit count is the units digit of the instruction's address field.

A command is loaded with a one-cycle `start` while the unit is idle. The pair moves one digit per clock, and the boundary digit crosses between the halves on each move. `done` pulses for one cycle when the result is ready on the outputs. The unit also reports an overflow flag and the number of drum word-times the command occupies. That figure depends on the drum position parity given with the command.

The control is a five-state machine. IDLE waits for `start`. NORM_TEST is entered only by the normalise command and picks its branch. SHIFT moves one digit per cycle. ROUND is entered only by the rounding command. DONE lasts one cycle and asserts `done`. The transitions are as follows. IDLE goes to NORM_TEST for a normalise command. For any other command with a count of zero, IDLE skips SHIFT and goes straight to ROUND or DONE; otherwise it goes to SHIFT. NORM_TEST goes to DONE when the upper half is zero or already normalised, and to SHIFT otherwise. SHIFT loops on itself, then leaves for ROUND or DONE. ROUND goes to DONE, and DONE goes to IDLE.

Top module: `dec_shift_unit`

## Requirements
- R1: After reset the unit is idle: `busy` and `done` are 0, and the accumulator outputs, sign, overflow and word-time count are all 0.
- R2: `start` is taken only in IDLE. Counting clock edges after the edge that samples `start`, `done` goes high after N edges for a left or right move of N digits. It goes high after N+1 edges for the rounding command, and after 1+S edges for normalise, where S is the number of digits moved. `done` is a single-cycle pulse, and the unit is idle in the cycle after it.
- R3: Command code 2'b00 (left move) moves the 20-digit magnitude left by N digits, where N is `shift_digit` (0 to 9). The top digit of the upper half is lost, the top digit of the lower half enters the bottom of the upper half, and zeros enter at the bottom.
- R4: Command code 2'b01 (right move) moves the magnitude right by N digits. The bottom digit of the upper half enters the top of the lower half, the bottom digit of the lower half is lost, and zeros enter at the top. For both plain moves and for rounding, the sign (1 = negative) is kept, even when the magnitude becomes zero. The result is then a minus zero.
- R5: Command code 2'b10 (right move and round) moves right by N digits. If N > 0 and the last digit lost is 5 or more, the magnitude is raised by one, with the carry running through both halves, and the sign is kept. Overflow is always 0 after this command.
- R6: For the left and right moves, the overflow output equals `ovf_in` captured at start.
- R7: Command code 2'b11 (normalise) starts a count at 10 minus `shift_digit`, with 0 for a digit of 0. It applies when the upper half is nonzero but its top digit is zero. The unit moves left one digit at a time and adds one to the count per move, stopping once the top digit is nonzero. If that takes more than 10 minus the start count moves, the unit stops after 11 minus the start count moves, with the count at 10 and overflow set. Otherwise overflow equals `ovf_in`. The lower half's bottom two digits are then replaced by the count as two decimal digits.
- R8: Normalise with an all-zero upper half moves the lower half into the upper half and sets the lower half to 0000000010, with no moves counted. Overflow becomes `ovf_in`, or 1 if the start count is nonzero, or 1 if the new top digit is zero.
- R9: Normalise with a nonzero top digit in the upper half moves nothing and replaces the lower half's bottom two digits with 00. Overflow stays `ovf_in`. Normalise of an all-zero magnitude gives a positive result.
- R10: At `done`, `word_times` equals 3, plus 1 when `pos_odd` is 1, plus 2 per digit moved, plus 1 for the rounding command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a command (sampled in IDLE) |
| op_sel | input | 2 | Command: 00 left, 01 right, 10 right and round, 11 normalise |
| shift_digit | input | 4 | Units digit of the address field, 0 to 9 |
| pos_odd | input | 1 | Drum position is odd, costing one alignment word-time |
| upper_in | input | 40 | Upper half, BCD |
| lower_in | input | 40 | Lower half, BCD |
| sign_in | input | 1 | Accumulator sign, 1 = negative |
| ovf_in | input | 1 | Overflow flag before the command |
| busy | output | 1 | Command in progress (NORM_TEST, SHIFT or ROUND) |
| done | output | 1 | One-cycle completion pulse |
| upper_out | output | 40 | Upper half result, BCD |
| lower_out | output | 40 | Lower half result, BCD |
| sign_out | output | 1 | Result sign |
| ovf_out | output | 1 | Result overflow flag |
| word_times | output | 5 | Word-times used by the command |

## Verification
The sweep covers every command against every field digit, both drum parities and eight accumulator patterns. The patterns were picked to reach the corners. A rounding carry ripples from the lower half into the upper half. A negative value shifts down to minus zero. Normalise runs through each of its three branches, and it hits the count limit both exactly at 10 and past it. A design that got the limit wrong would set overflow when the count lands on exactly 10, or would keep moving past it. A design that mishandled the boundary would drop or duplicate the digit that crosses between the halves. A design that mishandled the carry would round only within the lower half. Latency and word-time figures are compared on every run, so an extra or missing SHIFT cycle shows up directly.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    typedef enum logic [1:0] {
        OP_SHL  = 2'b00,
        OP_SHR  = 2'b01,
        OP_SRND = 2'b10,
        OP_NORM = 2'b11
    } dsr_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_NORM_TEST,
        S_SHIFT,
        S_ROUND,
        S_DONE
    } dsr_state_e;

    // decimal radix: the normalise count saturates here
    localparam logic [3:0] NORM_LIMIT = 4'd10;
    // fixed word-time overhead of every command
    localparam int BASE_WORDS = 3;

endpackage

// File: rtl/dsr_digit_shift.sv
module dsr_digit_shift #(
    parameter int NDIG = 20
) (
    input  logic [4*NDIG-1:0] din,
    input  logic              left,
    output logic [4*NDIG-1:0] dout,
    output logic [3:0]        spill
);
    localparam int MW = 4 * NDIG;

    always_comb begin
        if (left) begin
            dout  = {din[MW-5:0], 4'h0};
            spill = din[MW-1 -: 4];
        end else begin
            dout  = {4'h0, din[MW-1:4]};
            spill = din[3:0];
        end
    end
endmodule

// File: rtl/dsr_bcd_inc.sv
module dsr_bcd_inc #(
    parameter int NDIG = 20
) (
    input  logic [4*NDIG-1:0] din,
    output logic [4*NDIG-1:0] dout
);
    logic [NDIG:0] carry;
    assign carry[0] = 1'b1;

    for (genvar g = 0; g < NDIG; g++) begin : g_digit
        logic nine;
        assign nine         = (din[4*g +: 4] == 4'd9);
        assign carry[g+1]   = carry[g] & nine;
        assign dout[4*g +: 4] = !carry[g] ? din[4*g +: 4] :
                                nine      ? 4'd0 : din[4*g +: 4] + 4'd1;
    end
endmodule

// File: rtl/dsr_word_tally.sv
module dsr_word_tally #(
    parameter int WT_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [WT_W-1:0] base,
    input  logic            add_two,
    input  logic            add_one,
    output logic [WT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (load)    count <= base;
        else if (add_two) count <= count + WT_W'(2);
        else if (add_one) count <= count + WT_W'(1);
    end

    // R10
    tally_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> count >= $past(count));
endmodule

// File: rtl/dec_shift_unit.sv
module dec_shift_unit
    import dsr_pkg::*;
#(
    parameter int DIGITS = 10,
    parameter int WT_W   = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [1:0]          op_sel,
    input  logic [3:0]          shift_digit,
    input  logic                pos_odd,
    input  logic [4*DIGITS-1:0] upper_in,
    input  logic [4*DIGITS-1:0] lower_in,
    input  logic                sign_in,
    input  logic                ovf_in,
    output logic                busy,
    output logic                done,
    output logic [4*DIGITS-1:0] upper_out,
    output logic [4*DIGITS-1:0] lower_out,
    output logic                sign_out,
    output logic                ovf_out,
    output logic [WT_W-1:0]     word_times
);
    localparam int W      = 4 * DIGITS;
    localparam int MW     = 2 * W;
    localparam int WT_MAX = BASE_WORDS + 1 + 2 * 11 + 1;
    localparam logic [W-1:0] LO_TEN = {{(W-8){1'b0}}, 8'h10};

    dsr_state_e state_q, state_d;
    dsr_op_e    op_q;
    logic [MW-1:0] mag_q, sh_mag, inc_mag;
    logic [3:0]    spill, last_q, rem_q, cnt_q;
    logic          sign_q, ovf_q;
    logic [W-1:0]  up_q, lo_q;
    logic          top_nz, next_top_nz, norm_exit;
    logic [7:0]    stamp;

    assign up_q        = mag_q[MW-1:W];
    assign lo_q        = mag_q[W-1:0];
    assign top_nz      = (mag_q[MW-1 -: 4] != 4'd0);
    assign next_top_nz = (sh_mag[MW-1 -: 4] != 4'd0);
    assign norm_exit   = (cnt_q == NORM_LIMIT) || next_top_nz;
    assign stamp       = (cnt_q >= 4'd9) ? 8'h10 : {4'h0, cnt_q + 4'd1};

    dsr_digit_shift #(.NDIG(2*DIGITS)) u_shift (
        .din   (mag_q),
        .left  (op_q == OP_SHL || op_q == OP_NORM),
        .dout  (sh_mag),
        .spill (spill)
    );

    dsr_bcd_inc #(.NDIG(2*DIGITS)) u_inc (
        .din  (mag_q),
        .dout (inc_mag)
    );

    dsr_word_tally #(.WT_W(WT_W)) u_tally (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (state_q == S_IDLE && start),
        .base    (WT_W'(BASE_WORDS) + WT_W'(pos_odd)),
        .add_two (state_q == S_SHIFT),
        .add_one (state_q == S_ROUND),
        .count   (word_times)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) begin
                if (dsr_op_e'(op_sel) == OP_NORM)      state_d = S_NORM_TEST;
                else if (shift_digit != 4'd0)          state_d = S_SHIFT;
                else if (dsr_op_e'(op_sel) == OP_SRND) state_d = S_ROUND;
                else                                   state_d = S_DONE;
            end
            S_NORM_TEST: state_d = (up_q == '0 || top_nz) ? S_DONE : S_SHIFT;
            S_SHIFT: begin
                if (op_q == OP_NORM) begin
                    if (norm_exit) state_d = S_DONE;
                end else if (rem_q == 4'd1) begin
                    state_d = (op_q == OP_SRND) ? S_ROUND : S_DONE;
                end
            end
            S_ROUND: state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_SHL;
            mag_q  <= '0;
            sign_q <= 1'b0;
            ovf_q  <= 1'b0;
            rem_q  <= '0;
            cnt_q  <= '0;
            last_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    op_q   <= dsr_op_e'(op_sel);
                    mag_q  <= {upper_in, lower_in};
                    sign_q <= sign_in;
                    ovf_q  <= ovf_in;
                    rem_q  <= shift_digit;
                    cnt_q  <= (shift_digit == 4'd0) ? 4'd0 : NORM_LIMIT - shift_digit;
                    last_q <= 4'd0;
                end
                S_NORM_TEST: begin
                    sign_q <= sign_q && (mag_q != '0);
                    if (up_q == '0) begin
                        mag_q <= {lo_q, LO_TEN};
                        ovf_q <= ovf_q || (cnt_q != 4'd0) || (lo_q[W-1 -: 4] == 4'd0);
                    end else if (top_nz) begin
                        mag_q[7:0] <= 8'h00;
                    end
                end
                S_SHIFT: begin
                    if (op_q == OP_NORM) begin
                        mag_q <= norm_exit ? {sh_mag[MW-1:8], stamp} : sh_mag;
                        if (cnt_q == NORM_LIMIT) ovf_q <= 1'b1;
                        else                     cnt_q <= cnt_q + 4'd1;
                    end else begin
                        mag_q  <= sh_mag;
                        last_q <= spill;
                        rem_q  <= rem_q - 4'd1;
                    end
                end
                S_ROUND: begin
                    if (last_q >= 4'd5) mag_q <= inc_mag;
                    ovf_q <= 1'b0;
                end
                S_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q == S_NORM_TEST) || (state_q == S_SHIFT) || (state_q == S_ROUND);
        done      = (state_q == S_DONE);
        upper_out = up_q;
        lower_out = lo_q;
        sign_out  = sign_q;
        ovf_out   = ovf_q;
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);
    // R2
    start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start) |=> (busy || done));
    // R4
    sign_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SHIFT) |=> $stable(sign_q));
    // R5
    round_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_SRND) |-> !ovf_out);
    // R7
    norm_stamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_NORM) |-> (lower_out[7:0] <= 8'h10 && lower_out[3:0] <= 4'd9));
    // R10
    word_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (word_times >= WT_W'(BASE_WORDS) && word_times <= WT_W'(WT_MAX)));
endmodule

// File: tb/tb_dec_shift_unit.sv
module tb_dec_shift_unit;
    localparam int CLK_PERIOD = 10;
    localparam int D  = 10;
    localparam int W  = 4 * D;
    localparam int ND = 2 * D;

    logic         clk = 1'b0;
    logic         rst_n, start, pos_odd, sign_in, ovf_in;
    logic [1:0]   op_sel;
    logic [3:0]   shift_digit;
    logic [W-1:0] upper_in, lower_in;
    logic         busy, done, sign_out, ovf_out;
    logic [W-1:0] upper_out, lower_out;
    logic [4:0]   word_times;

    int checks = 0;
    int errors = 0;

    dec_shift_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .shift_digit(shift_digit), .pos_odd(pos_odd),
        .upper_in(upper_in), .lower_in(lower_in), .sign_in(sign_in), .ovf_in(ovf_in),
        .busy(busy), .done(done), .upper_out(upper_out), .lower_out(lower_out),
        .sign_out(sign_out), .ovf_out(ovf_out), .word_times(word_times)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    logic [W-1:0] pat_u [8];
    logic [W-1:0] pat_l [8];

    task automatic run_case(input int op, input int dig, input int odd,
                            input logic [W-1:0] u, input logic [W-1:0] l,
                            input logic s, input logic ov);
        int m [ND];
        int shifts = 0, last = 0, lat = 0, n0, n;
        logic es, eov;
        logic [W-1:0] eu, el;
        string tag, otag;
        bit upz, allz;
        for (int i = 0; i < D; i++) begin
            m[i]     = int'(l[4*i +: 4]);
            m[i + D] = int'(u[4*i +: 4]);
        end
        es = s; eov = ov;
        case (op)
            0: begin
                tag = "R3"; otag = "R6";
                for (int j = 0; j < dig; j++) begin
                    for (int i = ND-1; i > 0; i--) m[i] = m[i-1];
                    m[0] = 0;
                end
                shifts = dig;
            end
            1, 2: begin
                tag = (op == 1) ? "R4" : "R5"; otag = (op == 1) ? "R6" : "R5";
                for (int j = 0; j < dig; j++) begin
                    last = m[0];
                    for (int i = 0; i < ND-1; i++) m[i] = m[i+1];
                    m[ND-1] = 0;
                end
                shifts = dig;
                if (op == 2) begin
                    if (last >= 5) begin
                        for (int i = 0; i < ND; i++) begin
                            if (m[i] == 9) m[i] = 0;
                            else begin m[i] = m[i] + 1; break; end
                        end
                    end
                    eov = 1'b0;
                end
            end
            default: begin
                n0 = (dig == 0) ? 0 : 10 - dig;
                upz = 1; allz = 1;
                for (int i = 0; i < ND; i++) begin
                    if (m[i] != 0) allz = 0;
                    if (i >= D && m[i] != 0) upz = 0;
                end
                if (allz) es = 1'b0;
                if (upz) begin
                    tag = "R8";
                    for (int i = 0; i < D; i++) begin m[i + D] = m[i]; m[i] = 0; end
                    m[1] = 1;
                    if (n0 != 0 || m[ND-1] == 0) eov = 1'b1;
                end else if (m[ND-1] != 0) begin
                    tag = "R9";
                    m[0] = 0; m[1] = 0;
                end else begin
                    tag = "R7";
                    n = n0;
                    while (m[ND-1] == 0) begin
                        for (int i = ND-1; i > 0; i--) m[i] = m[i-1];
                        m[0] = 0;
                        shifts++;
                        if (n == 10) begin eov = 1'b1; break; end
                        n++;
                    end
                    m[1] = n / 10; m[0] = n % 10;
                end
                otag = tag;
            end
        endcase
        for (int i = 0; i < D; i++) begin
            el[4*i +: 4] = 4'(m[i]);
            eu[4*i +: 4] = 4'(m[i + D]);
        end

        @(negedge clk);
        op_sel = 2'(op); shift_digit = 4'(dig); pos_odd = odd[0];
        upper_in = u; lower_in = l; sign_in = s; ovf_in = ov; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        while (!done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        // R2 latency: one clock per digit plus fixed states
        check("R2", "latency", 64'(lat), 64'((op == 3) ? 1 + shifts : dig + (op == 2 ? 1 : 0)));
        check(tag, "upper", 64'(upper_out), 64'(eu));
        check(tag, "lower", 64'(lower_out), 64'(el));
        check((op == 3) ? tag : "R4", "sign", 64'(sign_out), 64'(es));
        check(otag, "ovf", 64'(ovf_out), 64'(eov));
        // R10 word-time accounting
        check("R10", "word_times", 64'(word_times),
              64'(3 + odd + 2 * shifts + (op == 2 ? 1 : 0)));
        @(negedge clk);
        // R2 single-cycle done, idle afterwards
        check("R2", "done_busy_after", 64'({done, busy}), 64'(0));
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        pat_u[0] = 40'h0000000000; pat_l[0] = 40'h9876543210;
        pat_u[1] = 40'h0000000000; pat_l[1] = 40'h0012345678;
        pat_u[2] = 40'h0000000000; pat_l[2] = 40'h0000000000;
        pat_u[3] = 40'h1234567890; pat_l[3] = 40'h5555555555;
        pat_u[4] = 40'h0000004999; pat_l[4] = 40'h9999999999;
        pat_u[5] = 40'h0000000007; pat_l[5] = 40'h4500000000;
        pat_u[6] = 40'h0090000000; pat_l[6] = 40'h0000000005;
        pat_u[7] = 40'h0000000999; pat_l[7] = 40'h9999999995;

        rst_n = 1'b0; start = 1'b0; op_sel = 2'b00; shift_digit = 4'd0; pos_odd = 1'b0;
        upper_in = '0; lower_in = '0; sign_in = 1'b0; ovf_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "busy_done", 64'({busy, done}), 64'(0));
        check("R1", "upper", 64'(upper_out), 64'(0));
        check("R1", "lower", 64'(lower_out), 64'(0));
        check("R1", "sign_ovf", 64'({sign_out, ovf_out}), 64'(0));
        check("R1", "word_times", 64'(word_times), 64'(0));

        for (int op = 0; op < 4; op++)
            for (int dig = 0; dig < 10; dig++)
                for (int odd = 0; odd < 2; odd++)
                    for (int p = 0; p < 8; p++)
                        run_case(op, dig, odd, pat_u[p], pat_l[p],
                                 logic'((dig + p) % 2), logic'((p + op) % 3 == 0));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule